// File: doc/BRIEF.md
# SD host vendor register front-end

This block is the register face of an SD host controller. A 32-bit register bus reaches a 4 KiB window through it. The lower 512 bytes hold a small set of vendor-specific host registers. Accesses at byte offset 0x200 and above go, unchanged, to a slot-register port that feeds a standard slot controller. The slot controller is outside this block, and so are the PHY and the SD bus protocol.

A few vendor registers have side effects when written:

- The identification word can issue a software reset. That reset clears the vendor registers and pulses a reset to the slot controller.
- The PHY access word acknowledges any read or write request written into it.
- The eMMC control word drops its tuning request bit, so that bit never reads back as set.

Any access that is not a full, aligned 32-bit word is refused and flagged. The slot controller's interrupt line passes straight through to the block's interrupt output.

Top module: `sdh_vreg_frontend`

## Requirements
- R1: A cycle with `rst` high resets the block. `slot_rst` is high in the cycle after each reset cycle and low after the first non-reset edge. All vendor words other than offset 0x000 then read zero, and `bus_err` is low.
- R2: The word at offset 0x000 always reads 0x00010000. A write to it with bit 0 clear changes nothing.
- R3: A full write to offset 0x000 with bit 0 set clears every other vendor word to zero. A read issued in the next cycle already returns zero.
- R4: That same write drives `slot_rst` high for exactly one cycle, the cycle after the write. No register bit keeps a record of it.
- R5: At offset 0x010 the written value is stored with bit 26 replaced by (bit 24 OR bit 25) of the written data.
- R6: At offset 0x018 the written value is stored with bit 15 forced to 0.
- R7: Every other vendor offset from 0x004 to 0x1FC stores the written word and reads it back unchanged.
- R8: When `bus_rd` is sampled at an edge, `bus_rdata` shows the result in the following cycle. In a cycle not preceded by a read, `bus_rdata` is zero.
- R9: A full access at offset 0x200 or above raises `slot_wr` or `slot_rd` in the same cycle. In that cycle, `slot_addr` equals the offset minus 0x200 and `slot_wdata` equals `bus_wdata`. Such an access leaves the vendor words untouched. For a read, `slot_rdata` is sampled at the request edge and shown on `bus_rdata` in the next cycle.
- R10: `irq` follows `slot_irq` combinationally.
- R11: An access with `bus_be` not equal to 4'hF, or with `bus_addr[1:0]` nonzero, is refused. It writes nothing, raises no slot strobe, reads zero, and raises `bus_err` for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle flag for a refused access |
| slot_addr | output | 12 | Offset inside the slot register set |
| slot_wr | output | 1 | Forwarded write strobe |
| slot_rd | output | 1 | Forwarded read strobe |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Read data from the slot controller |
| slot_rst | output | 1 | Reset to the slot controller |
| slot_irq | input | 1 | Slot controller interrupt |
| irq | output | 1 | Interrupt output |

## Verification
Two functions can land on the same cycle:

- A software-reset write that clears the vendor words, and a read of a vendor word in the very next cycle. That read must already see the cleared value.
- The hardware reset and the software-reset pulse, which share `slot_rst`.

The bench sets up each case:

- It fills words with random data, then follows the clearing write immediately with reads.
- It asserts `rst` in the middle of the random traffic.
- It checks `slot_rst` cycle by cycle against a pulse width it predicts itself, and compares every read with its own register model.

// File: rtl/sdh_vreg_pkg.sv
package sdh_vreg_pkg;
  // Value reported by the identification word at offset 0x000
  localparam logic [31:0] ID_WORD_VALUE = 32'h0001_0000;
  // Word indices whose write side effects the logic decodes
  localparam int unsigned W_IDENT = 0;
  localparam int unsigned W_PHY   = 4;
  localparam int unsigned W_EMMC  = 6;
  // Bit positions with side effects
  localparam int unsigned B_SOFT_RST = 0;
  localparam int unsigned B_PHY_WREQ = 24;
  localparam int unsigned B_PHY_RREQ = 25;
  localparam int unsigned B_PHY_ACK  = 26;
  localparam int unsigned B_TUNE     = 15;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_VREG = 2'd1,
    RSP_SLOT = 2'd2
  } rsp_kind_t;
endpackage

// File: rtl/sdh_vreg_decode.sv
module sdh_vreg_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BE_W      = 4,
  parameter int unsigned SLOT_BASE = 512,
  parameter int unsigned VIDX_W    = 7
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              wr_v,
  output logic              rd_v,
  output logic              wr_s,
  output logic              rd_s,
  output logic              refused,
  output logic [VIDX_W-1:0] vidx,
  output logic [ADDR_W-1:0] slot_off
);
  localparam int unsigned OFS_W = $clog2(BE_W);

  logic full_ok;
  logic in_slot;

  always_comb begin
    full_ok  = (bus_be == {BE_W{1'b1}}) && (bus_addr[OFS_W-1:0] == '0);
    in_slot  = (bus_addr >= ADDR_W'(SLOT_BASE));
    wr_v     = bus_wr && full_ok && !in_slot;
    rd_v     = bus_rd && full_ok && !in_slot;
    wr_s     = bus_wr && full_ok && in_slot;
    rd_s     = bus_rd && full_ok && in_slot;
    refused  = (bus_wr || bus_rd) && !full_ok;
    vidx     = bus_addr[VIDX_W+OFS_W-1:OFS_W];
    slot_off = bus_addr - ADDR_W'(SLOT_BASE);
  end
endmodule

// File: rtl/sdh_vreg_store.sv
module sdh_vreg_store
  import sdh_vreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              swr_hit
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  valid_q;
  logic [DATA_W-1:0] mem_rd_q;
  logic              vld_rd_q;
  logic              id_rd_q;
  logic [DATA_W-1:0] shaped;
  logic              is_ident;

  always_comb begin
    is_ident = (idx == IDX_W'(W_IDENT));
    swr_hit  = wr_en && is_ident && wdata[B_SOFT_RST] && !rst;
    shaped   = wdata;
    if (idx == IDX_W'(W_PHY))
      shaped[B_PHY_ACK] = wdata[B_PHY_WREQ] | wdata[B_PHY_RREQ];
    if (idx == IDX_W'(W_EMMC))
      shaped[B_TUNE] = 1'b0;
  end

  // Storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en && !is_ident)
      mem[idx] <= shaped;
    if (rd_en)
      mem_rd_q <= mem[idx];
  end

  // Per-word valid bits stand in for the reset of the RAM contents
  always_ff @(posedge clk) begin
    if (rst || swr_hit) begin
      valid_q  <= '0;
      vld_rd_q <= 1'b0;
      id_rd_q  <= 1'b0;
    end else begin
      if (wr_en && !is_ident)
        valid_q[idx] <= 1'b1;
      if (rd_en) begin
        vld_rd_q <= valid_q[idx];
        id_rd_q  <= is_ident;
      end
    end
  end

  always_comb begin
    if (id_rd_q)
      rd_data = DATA_W'(ID_WORD_VALUE);
    else if (vld_rd_q)
      rd_data = mem_rd_q;
    else
      rd_data = '0;
  end

  // R3: a software reset leaves no vendor word marked valid
  a_r3_swr_clears: assert property (@(posedge clk) disable iff (rst)
    swr_hit |=> (valid_q == '0));
  // R7: a plain write marks its word as holding data
  a_r7_write_marks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_ident) |=> valid_q[$past(idx)]);
endmodule

// File: rtl/sdh_vreg_frontend.sv
module sdh_vreg_frontend
  import sdh_vreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLOT_BASE = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_wr,
  output logic              slot_rd,
  output logic [DATA_W-1:0] slot_wdata,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              slot_rst,
  input  logic              slot_irq,
  output logic              irq
);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned VWORDS = SLOT_BASE / BE_W;
  localparam int unsigned VIDX_W = $clog2(VWORDS);

  logic              wr_v, rd_v, wr_s, rd_s, refused;
  logic [VIDX_W-1:0] vidx;
  logic [ADDR_W-1:0] slot_off;
  logic [DATA_W-1:0] vreg_rd;
  logic              swr_hit;
  rsp_kind_t         kind_q;
  logic [DATA_W-1:0] slot_q;

  sdh_vreg_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .SLOT_BASE(SLOT_BASE), .VIDX_W(VIDX_W)
  ) dec_i (
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .wr_v(wr_v), .rd_v(rd_v), .wr_s(wr_s), .rd_s(rd_s), .refused(refused),
    .vidx(vidx), .slot_off(slot_off)
  );

  sdh_vreg_store #(
    .DATA_W(DATA_W), .WORDS(VWORDS), .IDX_W(VIDX_W)
  ) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_v), .rd_en(rd_v), .idx(vidx),
    .wdata(bus_wdata), .rd_data(vreg_rd), .swr_hit(swr_hit)
  );

  // Slot pass-through
  always_comb begin
    slot_addr  = slot_off;
    slot_wr    = wr_s;
    slot_rd    = rd_s;
    slot_wdata = bus_wdata;
    irq        = slot_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= RSP_IDLE;
      slot_q   <= '0;
      bus_err  <= 1'b0;
      slot_rst <= 1'b1;
    end else begin
      bus_err  <= refused;
      slot_rst <= swr_hit;
      if (rd_v)       kind_q <= RSP_VREG;
      else if (rd_s)  kind_q <= RSP_SLOT;
      else            kind_q <= RSP_IDLE;
      if (rd_s) slot_q <= slot_rdata;
    end
  end

  always_comb begin
    case (kind_q)
      RSP_VREG: bus_rdata = vreg_rd;
      RSP_SLOT: bus_rdata = slot_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: the identification word reads its fixed value
  a_r2_id_value: assert property (@(posedge clk) disable iff (rst)
    (rd_v && vidx == '0) |=> (bus_rdata == DATA_W'(ID_WORD_VALUE)));
  // R4: slot reset only follows a reset cycle or a software reset write
  a_r4_slot_rst_cause: assert property (@(posedge clk) disable iff (rst)
    slot_rst |-> ($past(rst) || $past(swr_hit)));
  // R11: a refused access never reaches the slot port
  a_r11_no_fwd: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && (bus_be != '1)) |-> (!slot_wr && !slot_rd));
  // R11: the error cycle carries no read data
  a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));
  // R9: slot strobes only appear for offsets inside the slot window
  a_r9_slot_window: assert property (@(posedge clk) disable iff (rst)
    (slot_wr || slot_rd) |-> (bus_addr >= ADDR_W'(SLOT_BASE)));
endmodule

// File: tb/sdh_vreg_frontend_tb_top.sv
`timescale 1ns/1ps
module sdh_vreg_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [11:0] slot_addr;
  logic        slot_wr, slot_rd;
  logic [31:0] slot_wdata;
  logic [31:0] slot_rdata;
  logic        slot_rst;
  logic        slot_irq = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] ref_m [128];

  always #2 clk = ~clk;

  function automatic logic [31:0] slot_model(input logic [11:0] a);
    return 32'hC0DE_0000 ^ {20'h0, a};
  endfunction

  function automatic logic [31:0] exp_store(input int idx, input logic [31:0] d);
    logic [31:0] v = d;
    if (idx == 4) v[26] = d[24] | d[25];
    if (idx == 6) v[15] = 1'b0;
    return v;
  endfunction

  assign slot_rdata = slot_model(slot_addr);

  sdh_vreg_frontend dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .slot_addr(slot_addr),
    .slot_wr(slot_wr), .slot_rd(slot_rd), .slot_wdata(slot_wdata),
    .slot_rdata(slot_rdata), .slot_rst(slot_rst), .slot_irq(slot_irq),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ref();
    for (int i = 0; i < 128; i++) ref_m[i] = '0;
  endtask

  task automatic access(input bit is_wr, input logic [11:0] addr,
                        input logic [31:0] data, input logic [3:0] be,
                        input string tag);
    bit ok, sl, fw;
    int idx;
    logic [31:0] expd;
    ok  = (be == 4'hF) && (addr[1:0] == 2'b00);
    sl  = (addr >= 12'h200);
    idx = int'(addr[8:2]);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_be = be;
    bus_wr = is_wr; bus_rd = !is_wr;
    #1;
    fw = ok && sl;
    chk(slot_wr === (is_wr && fw), ok ? "R9" : "R11", 32'(slot_wr), 32'(is_wr && fw));
    chk(slot_rd === (!is_wr && fw), ok ? "R9" : "R11", 32'(slot_rd), 32'(!is_wr && fw));
    if (fw) begin
      chk(slot_addr == addr - 12'h200, "R9", 32'(slot_addr), 32'(addr - 12'h200));
      if (is_wr) chk(slot_wdata == data, "R9", slot_wdata, data);
    end
    @(negedge clk);
    chk(bus_err == !ok, "R11", 32'(bus_err), 32'(!ok));
    if (!is_wr) begin
      if (!ok) expd = '0;
      else if (sl) expd = slot_model(addr - 12'h200);
      else if (idx == 0) expd = 32'h0001_0000;
      else expd = ref_m[idx];
      chk(bus_rdata == expd, ok ? tag : "R11", bus_rdata, expd);
    end else begin
      chk(bus_rdata == '0, "R8", bus_rdata, 32'h0);
      if (ok && !sl && idx != 0) ref_m[idx] = exp_store(idx, data);
      if (ok && !sl && idx == 0 && data[0]) begin
        clear_ref();
        chk(slot_rst == 1'b1, "R4", 32'(slot_rst), 32'h1);
      end
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (is_wr && ok && !sl && idx == 0 && data[0]) begin
      @(negedge clk);
      chk(slot_rst == 1'b0, "R4", 32'(slot_rst), 32'h0);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(slot_rst == 1'b1, "R1", 32'(slot_rst), 32'h1);
    @(negedge clk);
    chk(slot_rst == 1'b1, "R1", 32'(slot_rst), 32'h1);
    rst = 1'b0;
    clear_ref();
    @(negedge clk);
    chk(slot_rst == 1'b0, "R1", 32'(slot_rst), 32'h0);
    chk(bus_err == 1'b0, "R1", 32'(bus_err), 32'h0);
    chk(bus_rdata == '0, "R1", bus_rdata, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_ref();
    hard_reset();
    // R1: every vendor word reads its reset value
    for (int i = 0; i < 128; i++) access(1'b0, 12'(i * 4), '0, 4'hF, "R1");
    // R2: identification word ignores writes without bit 0
    access(1'b1, 12'h000, 32'hFFFF_FFFE, 4'hF, "R2");
    access(1'b0, 12'h000, '0, 4'hF, "R2");
    // R5: acknowledge follows request bits
    access(1'b1, 12'h010, 32'h0100_0000, 4'hF, "R5");
    access(1'b0, 12'h010, '0, 4'hF, "R5");
    access(1'b1, 12'h010, 32'h0200_00AA, 4'hF, "R5");
    access(1'b0, 12'h010, '0, 4'hF, "R5");
    access(1'b1, 12'h010, 32'h0400_1234, 4'hF, "R5");
    access(1'b0, 12'h010, '0, 4'hF, "R5");
    access(1'b1, 12'h010, 32'hFFFF_FFFF, 4'hF, "R5");
    access(1'b0, 12'h010, '0, 4'hF, "R5");
    // R6: tuning bit never stored
    access(1'b1, 12'h018, 32'hFFFF_FFFF, 4'hF, "R6");
    access(1'b0, 12'h018, '0, 4'hF, "R6");
    // R7: boundary words of the vendor range
    access(1'b1, 12'h004, 32'h1357_9BDF, 4'hF, "R7");
    access(1'b1, 12'h1FC, 32'hDEAD_BEEF, 4'hF, "R7");
    access(1'b0, 12'h004, '0, 4'hF, "R7");
    access(1'b0, 12'h1FC, '0, 4'hF, "R7");
    // R9: slot window edges, vendor word untouched by slot write
    access(1'b1, 12'h200, 32'hA5A5_0001, 4'hF, "R9");
    access(1'b1, 12'hFFC, 32'hA5A5_0002, 4'hF, "R9");
    access(1'b0, 12'h204, '0, 4'hF, "R9");
    access(1'b0, 12'h004, '0, 4'hF, "R9");
    // R11: refused accesses
    access(1'b1, 12'h004, 32'h0, 4'h7, "R11");
    access(1'b1, 12'h006, 32'h0, 4'hF, "R11");
    access(1'b1, 12'h300, 32'h1, 4'h1, "R11");
    access(1'b0, 12'h000, '0, 4'h3, "R11");
    access(1'b0, 12'h004, '0, 4'hF, "R11");
    // R10: interrupt pass-through
    @(negedge clk); slot_irq = 1'b1; #1;
    chk(irq == 1'b1, "R10", 32'(irq), 32'h1);
    slot_irq = 1'b0; #1;
    chk(irq == 1'b0, "R10", 32'(irq), 32'h0);
    // Random traffic with software and hardware resets mixed in
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [11:0] a;
      logic [31:0] d;
      sel = int'($urandom % 16);
      d = $urandom;
      a = 12'($urandom % 128) << 2;
      if (sel < 5) begin
        if (a == 12'h000) d[0] = 1'b0;
        access(1'b1, a, d, 4'hF, "R7");
      end else if (sel < 10) access(1'b0, a, '0, 4'hF, "R8");
      else if (sel < 12) access(sel[0], 12'h200 + (12'($urandom % 896) << 2), d, 4'hF, "R9");
      else if (sel < 13) access(sel[0], 12'($urandom), d, 4'($urandom % 15), "R11");
      else if (sel < 14) begin
        access(1'b1, 12'h000, d | 32'h1, 4'hF, "R3");
        access(1'b0, 12'h004, '0, 4'hF, "R3");
        access(1'b0, 12'h010, '0, 4'hF, "R3");
      end else if (sel < 15) access(1'b1, 12'((4 + 2 * ($urandom % 2)) * 4), d, 4'hF, "R5");
      else if (n % 5 == 0) hard_reset();
      else access(1'b0, 12'((4 + 2 * ($urandom % 2)) * 4), '0, 4'hF, "R6");
    end
    // R3: full sweep after a clearing write
    for (int i = 1; i < 128; i++) access(1'b1, 12'(i * 4), 32'hFFFF_0000 | 32'(i), 4'hF, "R7");
    access(1'b1, 12'h000, 32'h0000_0001, 4'hF, "R3");
    for (int i = 0; i < 128; i++) access(1'b0, 12'(i * 4), '0, 4'hF, "R3");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule